// File: doc/BRIEF.md
# SRAM Page Address Generator

This block widens the 8-bit operand addresses of a small processor into an 11-bit SRAM address. It does so by adding a 3-bit page number in front of the operand address. The page depends on the kind of access. Five page registers hold the page numbers: current, index, stack, block-move source and block-move destination. A flag byte holds two page-mode bits. For ordinary and indexed accesses, these bits decide whether the page registers are used at all. Stack and block-move accesses always take their own page register, whatever the flags say.

The block also handles the page-mode side of interrupts. On interrupt entry the flag byte is presented for pushing and is then cleared, so a handler starts in page 0 for normal data. On return, the popped byte is reloaded into the flag register. The page registers themselves are never saved or restored.

The address is combinational from the register state, so the SRAM address is valid in the same cycle as the request.

Top module: `sram_page_addr`

## Requirements
- R1: After reset, all five page registers and the flag byte are zero, and every access kind produces `sram_addr = {3'b000, acc_addr}`.
- R2: With access code 0 (normal), the page is 0 when flag bit 7 is 0 and the current-page register when flag bit 7 is 1.
- R3: With access code 1 (indexed), the page is the index-page register when flag bits [7:6] are 2'b11, the current-page register when they are 2'b10, and 0 otherwise.
- R4: With access code 2 (stack), the page is the stack-page register whatever the flags are. The low byte passes through unchanged, so operand addresses FFh and 00h both stay in that page with no carry into the page field.
- R5: Access code 3 (block-move read) uses the source-page register and access code 4 (block-move write) uses the destination-page register, whatever the flags are.
- R6: A write with `wr_en` high loads the low 3 bits of `wr_data` into the register chosen by `wr_sel` at the next rising edge. The select codes are 0 current, 1 index, 2 stack, 3 source, 4 destination and 5 flag byte (all 8 bits); codes 6 and 7 write nothing.
- R7: `push_flags` always shows the flag register. A cycle with `irq_enter` high clears the flag register at the next edge, and this takes priority over a return or a flag write in the same cycle.
- R8: A cycle with `irq_return` high (and `irq_enter` low) loads `pop_flags` into the flag register at the next edge, and this takes priority over a flag write in the same cycle.
- R9: Interrupt entry and return leave all page registers unchanged. A page-register write in the same cycle as a return, or inside a handler, stays in effect afterwards.
- R10: The address responds to `acc_kind` and `acc_addr` in the same cycle, with no register on the path.
- R11: Access codes 5 to 7 produce page 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_kind | input | 3 | Access kind code |
| acc_addr | input | 8 | Operand address inside a page |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register write select |
| wr_data | input | 8 | Register write data |
| irq_enter | input | 1 | Interrupt entry strobe |
| irq_return | input | 1 | Return-from-interrupt strobe |
| pop_flags | input | 8 | Flag byte popped on return |
| sram_addr | output | 11 | Page and offset address to SRAM |
| push_flags | output | 8 | Current flag byte, to be pushed on entry |

## Verification
Two functions can fall in the same cycle: a flag-register update driven by an interrupt strobe, and a register write on the write port. The bench drives interrupt entry in the same cycle as a flag write of FFh, and expects the flags to come out cleared. It drives a return together with a current-page write, and expects both the restored flags and the new page to hold. It also drives a return together with a flag write, and expects the popped value to win. Each outcome is judged through `push_flags` and through addresses formed after the edge, which show the flag byte and the page registers at the ports.

// File: rtl/sram_page_pkg.sv
package sram_page_pkg;

   localparam int KIND_W = 3;
   localparam int SEL_W  = 3;
   localparam int NUM_PG = 5;

   typedef enum logic [KIND_W-1:0] {
      KIND_NORMAL = 3'd0,
      KIND_INDEX  = 3'd1,
      KIND_STACK  = 3'd2,
      KIND_MV_RD  = 3'd3,
      KIND_MV_WR  = 3'd4
   } acc_kind_e;

   // Write-select codes; page-register codes double as bank indices
   localparam logic [SEL_W-1:0] SEL_CUR  = 3'd0;
   localparam logic [SEL_W-1:0] SEL_IDX  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_STK  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_MVR  = 3'd3;
   localparam logic [SEL_W-1:0] SEL_MVW  = 3'd4;
   localparam logic [SEL_W-1:0] SEL_FLAG = 3'd5;

endpackage

// File: rtl/sram_page_regs.sv
module sram_page_regs
   import sram_page_pkg::*;
#(
   parameter int PAGE_W = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [SEL_W-1:0]               wr_sel,
   input  logic [PAGE_W-1:0]              wr_page,
   output logic [NUM_PG-1:0][PAGE_W-1:0]  pg_q
);

   generate
      for (genvar g = 0; g < NUM_PG; g++) begin : g_pg
         logic [PAGE_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
               q <= wr_page;
         end
         assign pg_q[g] = q;
      end
   endgenerate

   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && (wr_sel < SEL_W'(NUM_PG))) |=> $stable(pg_q)); // R9

   AST_PAGE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == SEL_STK)) |=> (pg_q[SEL_STK] == $past(wr_page))); // R6

endmodule

// File: rtl/sram_page_flags.sv
module sram_page_flags
   import sram_page_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_enter,
   input  logic              irq_return,
   input  logic [DATA_W-1:0] pop_flags,
   output logic [DATA_W-1:0] flags_q
);

   // Priority: entry clear, then return restore, then software write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags_q <= '0;
      else if (irq_enter)
         flags_q <= '0;
      else if (irq_return)
         flags_q <= pop_flags;
      else if (wr_en && (wr_sel == SEL_FLAG))
         flags_q <= wr_data;
   end

   AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      irq_enter |=> (flags_q == '0)); // R7

   AST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_return && !irq_enter) |=> (flags_q == $past(pop_flags))); // R8

   AST_FLAG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_sel == SEL_FLAG) && !irq_enter && !irq_return)
      |=> (flags_q == $past(wr_data))); // R6

endmodule

// File: rtl/sram_page_mux.sv
module sram_page_mux
   import sram_page_pkg::*;
#(
   parameter int PAGE_W = 3,
   parameter int ADDR_W = 8,
   localparam int SRAM_W = PAGE_W + ADDR_W
) (
   input  logic [KIND_W-1:0]              kind,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [1:0]                     mode,    // flag page-mode bits, upper first
   input  logic [NUM_PG-1:0][PAGE_W-1:0]  pg,
   output logic [SRAM_W-1:0]              sram_addr
);

   logic [PAGE_W-1:0] page;

   always_comb begin
      page = '0;
      unique case (acc_kind_e'(kind))
         KIND_NORMAL: if (mode[1]) page = pg[SEL_CUR];
         KIND_INDEX: begin
            if (mode == 2'b11)      page = pg[SEL_IDX];
            else if (mode == 2'b10) page = pg[SEL_CUR];
         end
         KIND_STACK: page = pg[SEL_STK];
         KIND_MV_RD: page = pg[SEL_MVR];
         KIND_MV_WR: page = pg[SEL_MVW];
         default:    page = '0;
      endcase
   end

   assign sram_addr = {page, addr};

endmodule

// File: rtl/sram_page_addr.sv
module sram_page_addr
   import sram_page_pkg::*;
#(
   parameter int PAGE_W = 3,
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   localparam int SRAM_W = PAGE_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        acc_kind,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              wr_en,
   input  logic [2:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              irq_enter,
   input  logic              irq_return,
   input  logic [DATA_W-1:0] pop_flags,
   output logic [SRAM_W-1:0] sram_addr,
   output logic [DATA_W-1:0] push_flags
);

   generate
      if (PAGE_W < 1 || PAGE_W > DATA_W) begin : g_bad_page
         $error("PAGE_W must lie between 1 and DATA_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must hold two page-mode bits");
      end
      if (ADDR_W < 1) begin : g_bad_addr
         $error("ADDR_W must be positive");
      end
   endgenerate

   logic [NUM_PG-1:0][PAGE_W-1:0] pg_q;
   logic [DATA_W-1:0]             flags_q;

   sram_page_regs #(.PAGE_W(PAGE_W)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_page (wr_data[PAGE_W-1:0]),
      .pg_q    (pg_q)
   );

   sram_page_flags #(.DATA_W(DATA_W)) i_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_sel     (wr_sel),
      .wr_data    (wr_data),
      .irq_enter  (irq_enter),
      .irq_return (irq_return),
      .pop_flags  (pop_flags),
      .flags_q    (flags_q)
   );

   sram_page_mux #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W)) i_mux (
      .kind      (acc_kind),
      .addr      (acc_addr),
      .mode      (flags_q[DATA_W-1:DATA_W-2]),
      .pg        (pg_q),
      .sram_addr (sram_addr)
   );

   assign push_flags = flags_q;

   AST_STACK_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == KIND_STACK) |-> (sram_addr[SRAM_W-1:ADDR_W] == pg_q[SEL_STK])); // R4

   AST_NORMAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((acc_kind == KIND_NORMAL) && !flags_q[DATA_W-1]) |-> (sram_addr[SRAM_W-1:ADDR_W] == '0)); // R2

   AST_MOVE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind == KIND_MV_WR) |-> (sram_addr[SRAM_W-1:ADDR_W] == pg_q[SEL_MVW])); // R5

   AST_UNUSED_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_kind > KIND_MV_WR) |-> (sram_addr[SRAM_W-1:ADDR_W] == '0)); // R11

   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      sram_addr[ADDR_W-1:0] == acc_addr); // R10

endmodule

// File: tb/test_sram_page_addr.sv
module test_sram_page_addr;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  acc_kind = '0;
   logic [7:0]  acc_addr = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [7:0]  wr_data = '0;
   logic        irq_enter = 1'b0;
   logic        irq_return = 1'b0;
   logic [7:0]  pop_flags = '0;
   logic [10:0] sram_addr;
   logic [7:0]  push_flags;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_page_addr i_sram_page_addr (
      .clk(clk), .rst_n(rst_n), .acc_kind(acc_kind), .acc_addr(acc_addr),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .irq_enter(irq_enter), .irq_return(irq_return), .pop_flags(pop_flags),
      .sram_addr(sram_addr), .push_flags(push_flags)
   );

   // {flags[7:0], kind[2:0], addr[7:0], expected[10:0]}
   // pages: cur=5 idx=3 stk=6 src=1 dst=7
   localparam logic [29:0] VEC [NVEC] = '{
      {8'h00, 3'd0, 8'h12, 11'h012},   // R2 mode off, R10
      {8'h80, 3'd0, 8'h12, 11'h512},   // R2 mode on
      {8'h40, 3'd0, 8'h34, 11'h034},   // R2 only lower bit
      {8'hC0, 3'd1, 8'h34, 11'h334},   // R3 index page
      {8'h80, 3'd1, 8'h34, 11'h534},   // R3 current page
      {8'h40, 3'd1, 8'h34, 11'h034},   // R3 page zero
      {8'h00, 3'd2, 8'hFF, 11'h6FF},   // R4 top of page
      {8'hC0, 3'd2, 8'h00, 11'h600},   // R4 bottom of page
      {8'h00, 3'd3, 8'h55, 11'h155},   // R5 read
      {8'hC0, 3'd4, 8'hAA, 11'h7AA},   // R5 write
      {8'h00, 3'd4, 8'h01, 11'h701},   // R5 write, flags clear
      {8'hC0, 3'd6, 8'h77, 11'h077}    // R11 unused code
   };
   localparam string VTAG [NVEC] = '{"R2","R2","R2","R3","R3","R3",
                                     "R4","R4","R5","R5","R5","R11"};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] sel, input logic [7:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic probe(input string tag, input logic [2:0] kind,
                        input logic [7:0] addr, input logic [10:0] exp);
      acc_kind = kind; acc_addr = addr;
      #1;
      check(tag, {21'd0, sram_addr}, {21'd0, exp});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 flags", {24'd0, push_flags}, 32'h0);
      for (int k = 0; k < 8; k++) probe("R1", 3'(k), 8'hA5, 11'h0A5);

      // R6 page writes keep low three bits; code 7 writes nothing
      wr_reg(3'd0, 8'hFD);
      wr_reg(3'd1, 8'h03);
      wr_reg(3'd2, 8'h0E);
      wr_reg(3'd3, 8'h01);
      wr_reg(3'd4, 8'h07);
      wr_reg(3'd7, 8'h02);
      wr_reg(3'd5, 8'hC0);
      check("R6 flag write", {24'd0, push_flags}, 32'hC0);
      probe("R6 stack", 3'd2, 8'h10, 11'h610);
      probe("R6 current", 3'd0, 8'h10, 11'h510);

      for (int v = 0; v < NVEC; v++) begin
         wr_reg(3'd5, VEC[v][29:22]);
         probe(VTAG[v], VEC[v][21:19], VEC[v][18:11], VEC[v][10:0]);
      end

      // R7 entry with simultaneous flag write
      wr_reg(3'd5, 8'hC0);
      @(negedge clk);
      irq_enter = 1'b1; wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'hFF;
      #1;
      check("R7 push value", {24'd0, push_flags}, 32'hC0);
      probe("R10 old mode this cycle", 3'd1, 8'h20, 11'h320);
      @(negedge clk);
      irq_enter = 1'b0; wr_en = 1'b0;
      #1;
      check("R7 cleared", {24'd0, push_flags}, 32'h0);
      probe("R7 handler page", 3'd0, 8'h20, 11'h020);
      probe("R9 stack kept", 3'd2, 8'h20, 11'h620);

      // R9 handler write, then return with current-page write
      wr_reg(3'd2, 8'h02);
      @(negedge clk);
      irq_return = 1'b1; pop_flags = 8'hC0;
      wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h04;
      @(negedge clk);
      irq_return = 1'b0; wr_en = 1'b0;
      #1;
      check("R8 restored", {24'd0, push_flags}, 32'hC0);
      probe("R9 current write kept", 3'd1, 8'h30, 11'h330);
      wr_reg(3'd5, 8'h80);
      probe("R9 current new", 3'd0, 8'h30, 11'h430);
      probe("R9 stack handler", 3'd2, 8'h30, 11'h230);

      // R8 return beats flag write
      @(negedge clk);
      irq_return = 1'b1; pop_flags = 8'h41;
      wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'h11;
      @(negedge clk);
      irq_return = 1'b0; wr_en = 1'b0;
      #1;
      check("R8 priority", {24'd0, push_flags}, 32'h41);

      // R7 entry beats return
      @(negedge clk);
      irq_enter = 1'b1; irq_return = 1'b1; pop_flags = 8'hFF;
      @(negedge clk);
      irq_enter = 1'b0; irq_return = 1'b0;
      #1;
      check("R7 over return", {24'd0, push_flags}, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule